// File: doc/BRIEF.md
# Cascaded DMA Request Router

This block is the request front end of a two-level DMA controller. Several raw request sources enter it. A programmable routing entry per source steers that source onto one of four slave channels. Per-channel mask bits then filter the slave channels. A priority stage picks one slave channel, and the winner is forwarded to the master level through a single cascade channel. The block hands the acknowledge back to the requesting source or sources and drives a transfer-go signal to the data path. Address generation, counting and bus cycles belong to other blocks.

A grant lasts as long as the chosen channel keeps requesting. A refresh stall or a snoop stall freezes the transfer-go output without withdrawing the grant or the acknowledge. The slave level has its own one-cycle software reset strobe, and so does the master level.

All pins are plain control signals. Nothing here carries a data stream, so the block has no valid/ready handshake and no back-pressure rules.

Top module: `dmar_top`

## Requirements
- R1: After `rst_n` is released, every slave channel is masked, the cascade channel is in normal mode and masked, and priority is fixed. With any requests raised, `src_ack` stays 0 and `xfer_go` stays 0.
- R2: Each source has a routing entry at register address equal to its index. Bit 2 of the entry enables it and bits 1:0 hold the slave channel. An enabled, unmasked route raises `src_ack` for that source and puts the channel on `grant_ch` at the first negative clock edge after the request.
- R3: A source whose entry has bit 2 clear is ignored. So is a source routed to a channel whose mask bit is set. The mask register is at address 8, with bit n set meaning channel n is masked. Sources that share a channel are ORed together and are acknowledged together.
- R4: Slave requests are granted only while the master control register (address 10) has bit 0 = 1 (cascade mode) and bit 1 = 0 (unmasked).
- R5: In fixed priority (address 9 bit 0 = 0), the lowest-numbered requesting channel wins.
- R6: In rotating priority (address 9 bit 0 = 1), the channel after the last serviced one has the highest priority, wrapping from 3 to 0.
- R7: A grant is held while its channel keeps requesting, even if a higher-priority request arrives. After the channel drops, there is one clock with no grant, and re-arbitration takes place at the following edge.
- R8: While `stall_refresh` or `stall_snoop` is high, `xfer_go` is 0 but the acknowledge and `grant_ch` stay. When the stall clears, `xfer_go` returns with the same grant.
- R9: A `slv_srst` pulse sets all slave mask bits, restores fixed priority and drops any grant. It wins over a register write in the same cycle.
- R10: A `mst_srst` pulse returns the cascade channel to normal mode and masked and drops any grant. It wins over a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| slv_srst | input | 1 | Slave-level software reset pulse |
| mst_srst | input | 1 | Master-level software reset pulse |
| src_req | input | NSRC (6) | Raw request lines, one per source |
| stall_refresh | input | 1 | Memory refresh stall |
| stall_snoop | input | 1 | Cache snoop stall |
| src_ack | output | NSRC (6) | Acknowledge, one per source |
| xfer_go | output | 1 | Transfer may proceed this cycle |
| grant_ch | output | 2 | Slave channel currently granted |

## Verification
Two functions can fall in the same clock edge: a software reset strobe and a register write that targets the same level. The bench provokes this by raising `slv_srst` together with a write that clears every mask bit, and by raising `mst_srst` together with a write that enables cascade mode. It judges the outcome at the ports: a request issued afterwards must get no acknowledge until the write is repeated on its own. A second overlap is a stall arriving while a grant is held. Here `xfer_go` must fall while `src_ack` and `grant_ch` stay unchanged.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_MASK = 4'h8;
  localparam logic [ADDR_W-1:0] A_PRIO = 4'h9;
  localparam logic [ADDR_W-1:0] A_CASC = 4'hA;

  typedef enum logic {
    PRIO_FIXED  = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;

  typedef struct packed {
    logic cascade;
    logic masked;
  } mst_cfg_t;
endpackage

// File: rtl/dmar_regs.sv
module dmar_regs
  import dmar_pkg::*;
#(
  parameter int unsigned NSRC = 6,
  parameter int unsigned NCH  = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   slv_srst,
  input  logic                   mst_srst,
  output logic [NSRC-1:0]        route_en,
  output logic [NSRC*CH_W-1:0]   route_ch,
  output logic [NCH-1:0]         ch_mask,
  output prio_mode_e             prio_mode,
  output mst_cfg_t               mst_cfg
);

  // one routing entry per source; enable sits just above the channel field
  for (genvar s = 0; s < NSRC; s++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route_en[s]                  <= 1'b0;
        route_ch[s*CH_W +: CH_W]     <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(s)) begin
        route_en[s]                  <= wr_data[CH_W];
        route_ch[s*CH_W +: CH_W]     <= wr_data[CH_W-1:0];
      end
    end
  end

  // slave level: masks and priority mode, software reset beats writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_mask   <= '1;
      prio_mode <= PRIO_FIXED;
    end else if (slv_srst) begin
      ch_mask   <= '1;
      prio_mode <= PRIO_FIXED;
    end else if (wr_en) begin
      if (wr_addr == A_MASK) ch_mask   <= wr_data[NCH-1:0];
      if (wr_addr == A_PRIO) prio_mode <= prio_mode_e'(wr_data[0]);
    end
  end

  // master level: cascade channel mode and mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_cfg <= '{cascade: 1'b0, masked: 1'b1};
    end else if (mst_srst) begin
      mst_cfg <= '{cascade: 1'b0, masked: 1'b1};
    end else if (wr_en && wr_addr == A_CASC) begin
      mst_cfg <= '{cascade: wr_data[0], masked: wr_data[1]};
    end
  end

  AST_SLV_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    slv_srst |=> (&ch_mask) && prio_mode == PRIO_FIXED); // R9
  AST_MST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mst_srst |=> !mst_cfg.cascade && mst_cfg.masked); // R10

endmodule

// File: rtl/dmar_route.sv
module dmar_route #(
  parameter int unsigned NSRC = 6,
  parameter int unsigned NCH  = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_req,
  input  logic [NSRC-1:0]      route_en,
  input  logic [NSRC*CH_W-1:0] route_ch,
  input  logic [NCH-1:0]       ch_mask,
  input  logic                 gnt_hold,
  input  logic [CH_W-1:0]      gnt_ch,
  output logic [NCH-1:0]       ch_req,
  output logic [NSRC-1:0]      src_ack
);

  logic [NCH-1:0] raw_req;

  // OR every enabled source onto its channel, then filter by mask
  always_comb begin
    raw_req = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (route_en[s] && src_req[s]) raw_req[route_ch[s*CH_W +: CH_W]] = 1'b1;
    end
    ch_req = raw_req & ~ch_mask;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_ack
    assign src_ack[s] = gnt_hold && route_en[s] && src_req[s]
                        && (route_ch[s*CH_W +: CH_W] == gnt_ch);
  end

  AST_ACK_ON_OPEN_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack != '0) |-> !ch_mask[gnt_ch]); // R3

endmodule

// File: rtl/dmar_arb.sv
module dmar_arb
  import dmar_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  ch_req,
  input  logic            casc_ok,
  input  prio_mode_e      prio_mode,
  input  logic            clr,
  output logic            gnt_active,
  output logic [CH_W-1:0] gnt_ch,
  output logic            gnt_hold
);

  logic [CH_W-1:0] last_ch;
  logic [CH_W-1:0] base;
  logic [CH_W-1:0] win;
  logic            found;

  // search starts at the top-priority slot and walks the ring
  always_comb begin
    base  = (prio_mode == PRIO_ROTATE) ? last_ch + 1'b1 : '0;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && ch_req[base + CH_W'(i)]) begin
        found = 1'b1;
        win   = base + CH_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_active <= 1'b0;
      gnt_ch     <= '0;
      last_ch    <= CH_W'(NCH-1);
    end else if (clr) begin
      gnt_active <= 1'b0;
      last_ch    <= CH_W'(NCH-1);
    end else if (gnt_active) begin
      if (!ch_req[gnt_ch]) gnt_active <= 1'b0;
    end else if (casc_ok && found) begin
      gnt_active <= 1'b1;
      gnt_ch     <= win;
      last_ch    <= win;
    end
  end

  assign gnt_hold = gnt_active && ch_req[gnt_ch];

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_hold && !clr) |=> gnt_active && $stable(gnt_ch)); // R7
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_active && !ch_req[gnt_ch]) |=> !gnt_active); // R7
  AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_active && casc_ok && prio_mode == PRIO_FIXED && ch_req[0] && !clr)
      |=> gnt_active && gnt_ch == '0); // R5

endmodule

// File: rtl/dmar_top.sv
module dmar_top
  import dmar_pkg::*;
#(
  parameter int unsigned NSRC = 6,
  parameter int unsigned NCH  = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              slv_srst,
  input  logic              mst_srst,
  input  logic [NSRC-1:0]   src_req,
  input  logic              stall_refresh,
  input  logic              stall_snoop,
  output logic [NSRC-1:0]   src_ack,
  output logic              xfer_go,
  output logic [CH_W-1:0]   grant_ch
);

  logic [NSRC-1:0]      route_en;
  logic [NSRC*CH_W-1:0] route_ch;
  logic [NCH-1:0]       ch_mask;
  prio_mode_e           prio_mode;
  mst_cfg_t             mst_cfg;
  logic [NCH-1:0]       ch_req;
  logic                 casc_ok;
  logic                 gnt_active;
  logic                 gnt_hold;
  logic                 stall_any;

  dmar_regs #(.NSRC(NSRC), .NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slv_srst(slv_srst), .mst_srst(mst_srst),
    .route_en(route_en), .route_ch(route_ch), .ch_mask(ch_mask),
    .prio_mode(prio_mode), .mst_cfg(mst_cfg)
  );

  dmar_route #(.NSRC(NSRC), .NCH(NCH)) u_route (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .route_en(route_en),
    .route_ch(route_ch), .ch_mask(ch_mask), .gnt_hold(gnt_hold),
    .gnt_ch(grant_ch), .ch_req(ch_req), .src_ack(src_ack)
  );

  assign casc_ok = mst_cfg.cascade && !mst_cfg.masked;

  dmar_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .casc_ok(casc_ok),
    .prio_mode(prio_mode), .clr(slv_srst || mst_srst),
    .gnt_active(gnt_active), .gnt_ch(grant_ch), .gnt_hold(gnt_hold)
  );

  assign stall_any = stall_refresh || stall_snoop;
  assign xfer_go   = gnt_hold && !stall_any;

  AST_GO_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> (src_ack != '0)); // R8
  AST_CASCADE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_active) |-> $past(casc_ok)); // R4

endmodule

// File: tb/tb_dmar_top.sv
module tb_dmar_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       slv_srst = 1'b0;
  logic       mst_srst = 1'b0;
  logic [5:0] src_req = '0;
  logic       stall_refresh = 1'b0;
  logic       stall_snoop = 1'b0;
  logic [5:0] src_ack;
  logic       xfer_go;
  logic [1:0] grant_ch;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dmar_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slv_srst(slv_srst), .mst_srst(mst_srst),
    .src_req(src_req), .stall_refresh(stall_refresh),
    .stall_snoop(stall_snoop), .src_ack(src_ack), .xfer_go(xfer_go),
    .grant_ch(grant_ch)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    src_req = '0;
    cyc(2);
  endtask

  task automatic t_reset();
    src_req = 6'h3F;
    cyc(2);
    chk("R1 ack", src_ack, 0);
    chk("R1 go", xfer_go, 0);
    idle();
  endtask

  task automatic t_config_cascade();
    wr(4'd0, 8'h4); wr(4'd1, 8'h5); wr(4'd2, 8'h6);
    wr(4'd3, 8'h7); wr(4'd4, 8'h5); wr(4'd5, 8'h3);
    wr(4'h8, 8'h0);
    src_req = 6'h01;
    cyc(2);
    chk("R4 normal mode", src_ack, 0);
    wr(4'hA, 8'h3);
    cyc(1);
    chk("R4 cascade masked", src_ack, 0);
    wr(4'hA, 8'h1);
    cyc(1);
    chk("R4 cascade open", src_ack, 6'h01);
    idle();
  endtask

  task automatic t_route();
    src_req = 6'h04;
    cyc(1);
    chk("R2 ack", src_ack, 6'h04);
    chk("R2 channel", grant_ch, 2);
    chk("R2 go", xfer_go, 1);
    idle();
  endtask

  task automatic t_or_ignore();
    src_req = 6'h12;
    cyc(1);
    chk("R3 shared ack", src_ack, 6'h12);
    chk("R3 shared channel", grant_ch, 1);
    idle();
    src_req = 6'h20;
    cyc(2);
    chk("R3 disabled route", src_ack, 0);
    idle();
    wr(4'h8, 8'h4);
    src_req = 6'h04;
    cyc(2);
    chk("R3 masked channel", src_ack, 0);
    chk("R3 masked go", xfer_go, 0);
    idle();
    wr(4'h8, 8'h0);
  endtask

  task automatic t_fixed_hold();
    src_req = 6'h0A;
    cyc(1);
    chk("R5 lowest wins", grant_ch, 1);
    chk("R5 ack", src_ack, 6'h02);
    src_req = 6'h08;
    cyc(1);
    chk("R7 gap cycle", src_ack, 0);
    cyc(1);
    chk("R7 rearbitrated", src_ack, 6'h08);
    chk("R7 new channel", grant_ch, 3);
    src_req = 6'h09;
    cyc(2);
    chk("R7 held vs higher", grant_ch, 3);
    chk("R7 held ack", src_ack, 6'h08);
    idle();
  endtask

  task automatic t_rotate();
    wr(4'h9, 8'h1);
    src_req = 6'h02;
    cyc(1);
    chk("R6 setup", grant_ch, 1);
    idle();
    src_req = 6'h05;
    cyc(1);
    chk("R6 after ch1", grant_ch, 2);
    chk("R6 ack", src_ack, 6'h04);
    src_req = 6'h01;
    cyc(2);
    chk("R6 wraps", grant_ch, 0);
    idle();
  endtask

  task automatic t_stall();
    stall_refresh = 1'b1;
    src_req = 6'h02;
    cyc(1);
    chk("R8 ack under stall", src_ack, 6'h02);
    chk("R8 go held", xfer_go, 0);
    stall_refresh = 1'b0;
    cyc(1);
    chk("R8 go resumes", xfer_go, 1);
    stall_snoop = 1'b1;
    cyc(1);
    chk("R8 snoop pause", xfer_go, 0);
    chk("R8 grant kept", grant_ch, 1);
    stall_snoop = 1'b0;
    cyc(1);
    chk("R8 resume same grant", {xfer_go, src_ack}, {1'b1, 6'h02});
    idle();
  endtask

  task automatic t_slv_reset();
    src_req = 6'h02;
    cyc(1);
    chk("R9 pre grant", src_ack, 6'h02);
    slv_srst = 1'b1; wr_en = 1'b1; wr_addr = 4'h8; wr_data = 8'h0;
    cyc(1);
    slv_srst = 1'b0; wr_en = 1'b0;
    chk("R9 grant dropped", src_ack, 0);
    src_req = 6'h01;
    cyc(2);
    chk("R9 masks restored", src_ack, 0);
    idle();
    wr(4'h8, 8'h0);
    src_req = 6'h09;
    cyc(1);
    chk("R9 fixed priority back", grant_ch, 0);
    idle();
  endtask

  task automatic t_mst_reset();
    mst_srst = 1'b1; wr_en = 1'b1; wr_addr = 4'hA; wr_data = 8'h1;
    cyc(1);
    mst_srst = 1'b0; wr_en = 1'b0;
    src_req = 6'h04;
    cyc(2);
    chk("R10 cascade closed", src_ack, 0);
    wr(4'hA, 8'h1);
    cyc(1);
    chk("R10 reopened", src_ack, 6'h04);
    idle();
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_config_cascade();
    t_route();
    t_or_ignore();
    t_fixed_hold();
    t_rotate();
    t_stall();
    t_slv_reset();
    t_mst_reset();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule